// File: doc/BRIEF.md
# Block Data FIFO with Byte Packing

This unit carries block data between a 32-bit host data register and a byte-wide card data port. A circular word FIFO sits between the two sides. When data flows from the card, incoming bytes are gathered into 32-bit words with the first byte in the least significant position. Each full word enters the FIFO. When the byte count runs out, a trailing partial word is flushed as well. When data flows toward the card, words leave the FIFO and are sent one byte at a time, lowest byte first.

A remaining-byte counter limits every transfer. It is loaded with block count times block size whenever software writes the block-count register. The unit sets a data flag each time a word enters or leaves the FIFO. It sets a block flag each time a block boundary is crossed. A debug register shows the live FIFO fill level and a small state field, which returns to its data-mode code when the count reaches zero. The `xferWrite` input selects the direction and must only change while the count is zero.

Top module: `sdPackEngine`

## Requirements
- R1: The FIFO holds DEPTH (default 16) 32-bit words in first-in first-out order. Its fill level is readable in bits 8:4 of the debug register (address 0x34).
- R2: A write to the block-count register (0x50, 9 bits) loads the remaining count with that value times the block size (0x3C, 10 bits). It also discards any partly packed word and any partly sent word.
- R3: While `xferWrite` is 0, `cardRxReady` is high only when all of these hold: the count is nonzero, the FIFO is not full, and no host write to 0x40 or 0x50 occurs in the same cycle. Each accepted byte decrements the count by one.
- R4: The first byte of a word lands in bits 7:0 and later bytes fill upward. A word is pushed after its fourth byte. When the count reaches zero, a partial word is pushed with its unfilled upper bytes at zero.
- R5: While `xferWrite` is 1, a word is popped into a holder whenever the holder is empty, the count is nonzero and the FIFO has data. Its bytes appear on `cardTxData` lowest first. `cardTxValid` is high only while the count is nonzero and the holder still has bytes.
- R6: Every push or pop sets status bit 0 (status register at 0x20). If config bit 4 (config register at 0x38) is set, it also sets status bit 8.
- R7: When config bit 8 is set and the block size is nonzero, status bit 9 is set by the byte transfer that leaves the remaining count at a multiple of the block size.
- R8: Bits 3:0 of the debug register are writable by the host. The byte transfer that brings the count to zero sets them to 1, unless the host writes the debug register in that same cycle.
- R9: A host read of 0x40 returns the oldest word and pops it. If the FIFO is empty, the read returns 0 and sets status bit 3. A host write to 0x40 pushes the word. If the FIFO is full, the write is dropped and sets status bit 3.
- R10: Writing 1s to the status register clears those bits. A flag that is set in the same cycle stays set.
- R11: After reset, the FIFO is empty and every register, counter and flag is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| xferWrite | input | 1 | Direction: 1 sends toward the card, 0 receives from it |
| regWrEn | input | 1 | Host register write strobe |
| regRdEn | input | 1 | Host register read strobe (a read of 0x40 pops) |
| regAddr | input | 8 | Host register address |
| regWdata | input | 32 | Host write data |
| regRdata | output | 32 | Host read data, valid in the same cycle as the read strobe |
| cardRxValid | input | 1 | Card byte available |
| cardRxData | input | 8 | Byte from the card |
| cardRxReady | output | 1 | Engine accepts the card byte this cycle |
| cardTxValid | output | 1 | Byte toward the card is valid |
| cardTxData | output | 8 | Byte toward the card |
| cardTxReady | input | 1 | Card takes the byte this cycle |

## Verification
The assertions assume the direction input and the block size stay fixed while a count is pending. Without that, the per-block counter and the holder logic would see a mix of two transfers. The bench writes the block size before the block count and switches direction only after a transfer has drained to zero. Card-side valid and ready are driven freely, including random patterns, so backpressure and bubbles occur in both directions. Host pops and pushes are interleaved with engine traffic, so the shared FIFO ports see both sources.

// File: rtl/sdPackPkg.sv
package sdPackPkg;
  localparam logic [7:0] ADDR_STATUS = 8'h20;
  localparam logic [7:0] ADDR_DEBUG  = 8'h34;
  localparam logic [7:0] ADDR_CONFIG = 8'h38;
  localparam logic [7:0] ADDR_BSIZE  = 8'h3C;
  localparam logic [7:0] ADDR_DATA   = 8'h40;
  localparam logic [7:0] ADDR_BCOUNT = 8'h50;

  localparam int ST_DATA  = 0;
  localparam int ST_FIFOERR = 3;
  localparam int ST_DATAIRQ = 8;
  localparam int ST_BLOCK = 9;
  localparam int CFG_DATAEN  = 4;
  localparam int CFG_BLOCKEN = 8;
  localparam logic [9:0] ST_MASK = 10'h309;
  localparam logic [3:0] STATE_DATAMODE = 4'h1;

  typedef struct packed {
    logic hostPush;
    logic hostPop;
    logic rxTake;
    logic rxFinish;
    logic txLoad;
    logic txTake;
    logic clearPack;
  } packStrobeT;
endpackage

// File: rtl/sdPackPath.sv
module sdPackPath
  import sdPackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  packStrobeT       strobe,
  input  logic [31:0]      hostWdata,
  input  logic [7:0]       rxByte,
  output logic [LEN_W-1:0] fillLevel,
  output logic [31:0]      headWord,
  output logic [1:0]       packIdx,
  output logic [2:0]       txLeft,
  output logic [7:0]       txByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] rdPos;
  logic [LEN_W-1:0] len;
  logic [31:0]      acc;
  logic [31:0]      txWord;
  logic [PTR_W:0]   slotSum;
  logic [PTR_W-1:0] wrSlot;
  logic [31:0]      packedWord;
  logic [31:0]      pushWord;
  logic             doPush;
  logic             doPop;

  assign doPush     = strobe.hostPush | strobe.rxFinish;
  assign doPop      = strobe.hostPop | strobe.txLoad;
  assign packedWord = acc | ({24'b0, rxByte} << {packIdx, 3'b000});
  assign pushWord   = strobe.hostPush ? hostWdata : packedWord;
  assign slotSum    = (PTR_W+1)'(rdPos) + (PTR_W+1)'(len);
  assign wrSlot     = (slotSum >= (PTR_W+1)'(DEPTH)) ? PTR_W'(slotSum - (PTR_W+1)'(DEPTH))
                                                     : PTR_W'(slotSum);
  assign headWord   = mem[rdPos];
  assign fillLevel  = len;
  assign txByte     = txWord[7:0];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrSlot] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPos <= '0;
      len   <= '0;
    end else begin
      if (doPop) rdPos <= (rdPos == PTR_W'(DEPTH - 1)) ? '0 : rdPos + 1'b1;
      if (doPush && !doPop)      len <= len + 1'b1;
      else if (doPop && !doPush) len <= len - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      packIdx <= '0;
      txWord  <= '0;
      txLeft  <= '0;
    end else if (strobe.clearPack) begin
      acc     <= '0;
      packIdx <= '0;
      txWord  <= '0;
      txLeft  <= '0;
    end else begin
      if (strobe.rxTake) begin
        acc     <= strobe.rxFinish ? '0 : packedWord;
        packIdx <= strobe.rxFinish ? '0 : packIdx + 1'b1;
      end
      if (strobe.txLoad) begin
        txWord <= headWord;
        txLeft <= 3'd4;
      end else if (strobe.txTake) begin
        txWord <= txWord >> 8;
        txLeft <= txLeft - 1'b1;
      end
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    doPush |-> (len < LEN_W'(DEPTH)));
  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    doPop |-> (len != '0));
  // R1
  fill_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && !doPop) |=> (len == $past(len) + 1'b1));
  // R5
  tx_load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txLoad |-> (txLeft == 3'd0));
endmodule

// File: rtl/sdPackCtrl.sv
module sdPackCtrl
  import sdPackPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = $clog2(DEPTH + 1),
  parameter int SIZE_W = 10,
  parameter int BLK_W  = 9,
  parameter int CNT_W  = SIZE_W + BLK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferWrite,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             cardRxValid,
  output logic             cardRxReady,
  output logic             cardTxValid,
  input  logic             cardTxReady,
  input  logic [LEN_W-1:0] fillLevel,
  input  logic [31:0]      headWord,
  input  logic [1:0]       packIdx,
  input  logic [2:0]       txLeft,
  output packStrobeT       strobe
);
  logic [10:0]       cfgReg;
  logic [SIZE_W-1:0] bsReg;
  logic [BLK_W-1:0]  bcReg;
  logic [CNT_W-1:0]  remCnt;
  logic [SIZE_W-1:0] blkLeft;
  logic [9:0]        statusReg;
  logic [3:0]        dbgState;
  logic [9:0]        stSet;
  logic [9:0]        stClr;
  logic wrData, rdData, wrBcount, wrStatus, wrDebug;
  logic isFull, isEmpty, cntLive, byteStep, dataEvt, blkEvt, fifoErr;

  assign wrData   = regWrEn && (regAddr == ADDR_DATA);
  assign rdData   = regRdEn && (regAddr == ADDR_DATA);
  assign wrBcount = regWrEn && (regAddr == ADDR_BCOUNT);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);
  assign wrDebug  = regWrEn && (regAddr == ADDR_DEBUG);
  assign isFull   = (fillLevel == LEN_W'(DEPTH));
  assign isEmpty  = (fillLevel == '0);
  assign cntLive  = (remCnt != '0);

  assign cardRxReady = !xferWrite && cntLive && !isFull && !wrData && !wrBcount;
  assign cardTxValid = xferWrite && cntLive && (txLeft != 3'd0) && !wrBcount;

  always_comb begin
    strobe           = '0;
    strobe.hostPush  = wrData && !isFull;
    strobe.hostPop   = rdData && !isEmpty;
    strobe.rxTake    = cardRxReady && cardRxValid;
    strobe.rxFinish  = strobe.rxTake && ((packIdx == 2'd3) || (remCnt == CNT_W'(1)));
    strobe.txTake    = cardTxValid && cardTxReady;
    strobe.txLoad    = xferWrite && cntLive && (txLeft == 3'd0) && !isEmpty && !rdData && !wrBcount;
    strobe.clearPack = wrBcount;
  end

  assign byteStep = strobe.rxTake || strobe.txTake;
  assign dataEvt  = strobe.hostPush || strobe.hostPop || strobe.rxFinish || strobe.txLoad;
  assign fifoErr  = (wrData && isFull) || (rdData && isEmpty);
  assign blkEvt   = byteStep && (bsReg != '0) && (blkLeft == SIZE_W'(1)) && cfgReg[CFG_BLOCKEN];

  always_comb begin
    stSet = '0;
    stSet[ST_DATA]    = dataEvt;
    stSet[ST_DATAIRQ] = dataEvt && cfgReg[CFG_DATAEN];
    stSet[ST_FIFOERR] = fifoErr;
    stSet[ST_BLOCK]   = blkEvt;
    stClr = wrStatus ? (regWdata[9:0] & ST_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg    <= '0;
      bsReg     <= '0;
      bcReg     <= '0;
      remCnt    <= '0;
      blkLeft   <= '0;
      statusReg <= '0;
      dbgState  <= '0;
    end else begin
      statusReg <= (statusReg & ~stClr) | stSet;
      if (regWrEn && regAddr == ADDR_CONFIG) cfgReg <= regWdata[10:0];
      if (regWrEn && regAddr == ADDR_BSIZE)  bsReg  <= regWdata[SIZE_W-1:0];
      if (wrBcount) begin
        bcReg   <= regWdata[BLK_W-1:0];
        remCnt  <= CNT_W'(regWdata[BLK_W-1:0]) * CNT_W'(bsReg);
        blkLeft <= bsReg;
      end else if (byteStep) begin
        remCnt  <= remCnt - 1'b1;
        blkLeft <= (blkLeft <= SIZE_W'(1)) ? bsReg : blkLeft - 1'b1;
      end
      if (wrDebug) dbgState <= regWdata[3:0];
      else if (byteStep && remCnt == CNT_W'(1)) dbgState <= STATE_DATAMODE;
    end
  end

  always_comb begin
    regRdata = '0;
    if (regRdEn) begin
      unique case (regAddr)
        ADDR_STATUS: regRdata = 32'(statusReg);
        ADDR_DEBUG:  regRdata = (32'(fillLevel) << 4) | 32'(dbgState);
        ADDR_CONFIG: regRdata = 32'(cfgReg);
        ADDR_BSIZE:  regRdata = 32'(bsReg);
        ADDR_BCOUNT: regRdata = 32'(bcReg);
        ADDR_DATA:   regRdata = isEmpty ? 32'h0 : headWord;
        default:     regRdata = '0;
      endcase
    end
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteStep && !wrBcount) |=> (remCnt == $past(remCnt) - 1'b1));
  // R8
  state_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteStep && remCnt == CNT_W'(1) && !wrDebug) |=> (dbgState == STATE_DATAMODE));
  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && isEmpty) |=> statusReg[ST_FIFOERR]);
  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrBcount |=> (remCnt == CNT_W'($past(regWdata[BLK_W-1:0])) * CNT_W'($past(bsReg))));
endmodule

// File: rtl/sdPackEngine.sv
module sdPackEngine
  import sdPackPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SIZE_W = 10,
  parameter int BLK_W  = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferWrite,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        cardRxValid,
  input  logic [7:0]  cardRxData,
  output logic        cardRxReady,
  output logic        cardTxValid,
  output logic [7:0]  cardTxData,
  input  logic        cardTxReady
);
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int CNT_W = SIZE_W + BLK_W;

  packStrobeT       strobe;
  logic [LEN_W-1:0] fillLevel;
  logic [31:0]      headWord;
  logic [1:0]       packIdx;
  logic [2:0]       txLeft;

  sdPackCtrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferWrite(xferWrite),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxReady(cardTxReady),
    .fillLevel(fillLevel), .headWord(headWord), .packIdx(packIdx), .txLeft(txLeft),
    .strobe(strobe)
  );

  sdPackPath #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWdata(regWdata), .rxByte(cardRxData),
    .fillLevel(fillLevel), .headWord(headWord), .packIdx(packIdx), .txLeft(txLeft),
    .txByte(cardTxData)
  );
endmodule

// File: tb/sdPackEngine_bench.sv
module sdPackEngine_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xferWrite = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic cardRxValid = 1'b0;
  logic [7:0] cardRxData = '0;
  logic cardRxReady, cardTxValid, cardTxReady = 1'b0;
  logic [7:0] cardTxData;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdPackEngine u_sdPackEngine (
    .clk(clk), .rstN(rstN), .xferWrite(xferWrite),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cardRxValid(cardRxValid), .cardRxData(cardRxData), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxData(cardTxData), .cardTxReady(cardTxReady)
  );

  // behavioural reference state
  logic [31:0] mq[$];
  int mcnt = 0, mbs = 0, mbc = 0, mcfg = 0, mstat = 0, mdbg = 0, midx = 0, mtxLeft = 0, mblk = 0;
  logic [31:0] macc = '0, mtxWord = '0;
  logic lastRxTake;
  logic [7:0] gotTx[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h20: return 32'(mstat);
      8'h34: return 32'((mq.size() << 4) | mdbg);
      8'h38: return 32'(mcfg);
      8'h3C: return 32'(mbs);
      8'h50: return 32'(mbc);
      8'h40: return (mq.size() != 0) ? mq[0] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [7:0] a);
    case (a)
      8'h20: return "R6";
      8'h34: return "R1";
      8'h40: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic modelStep();
    bit wrD, rdD, wrB, full, empty, rxRdy, txV, pushH, popH, rxT, rxF, txT, txL, stp;
    int setb, clr;
    logic [31:0] w, word;
    wrD = regWrEn && regAddr == 8'h40;
    rdD = regRdEn && regAddr == 8'h40;
    wrB = regWrEn && regAddr == 8'h50;
    full = mq.size() == 16;
    empty = mq.size() == 0;
    rxRdy = !xferWrite && mcnt != 0 && !full && !wrD && !wrB;
    txV = xferWrite && mcnt != 0 && mtxLeft != 0 && !wrB;
    pushH = wrD && !full;
    popH = rdD && !empty;
    rxT = rxRdy && cardRxValid;
    rxF = rxT && (midx == 3 || mcnt == 1);
    txT = txV && cardTxReady;
    txL = xferWrite && mcnt != 0 && mtxLeft == 0 && !empty && !rdD && !wrB;
    stp = rxT || txT;
    setb = 0;
    if (pushH || popH || rxF || txL) setb |= 1 | (mcfg[4] ? 32'h100 : 0);
    if ((wrD && full) || (rdD && empty)) setb |= 8;
    if (stp && mbs != 0 && mblk == 1 && mcfg[8]) setb |= 32'h200;
    word = macc | (32'(cardRxData) << (8 * midx));
    w = 0;
    if (popH || txL) w = mq.pop_front();
    if (pushH) mq.push_back(regWdata);
    if (rxF) mq.push_back(word);
    if (wrB) begin midx = 0; macc = 0; mtxLeft = 0; mtxWord = 0; end
    else begin
      if (rxT) begin
        if (rxF) begin midx = 0; macc = 0; end
        else begin macc = word; midx++; end
      end
      if (txL) begin mtxWord = w; mtxLeft = 4; end
      else if (txT) begin mtxWord = mtxWord >> 8; mtxLeft--; end
    end
    if (regWrEn && regAddr == 8'h34) mdbg = regWdata[3:0];
    else if (stp && mcnt == 1) mdbg = 1;
    if (wrB) begin mcnt = int'(regWdata[8:0]) * mbs; mblk = mbs; end
    else if (stp) begin mcnt--; mblk = (mblk <= 1) ? mbs : mblk - 1; end
    clr = (regWrEn && regAddr == 8'h20) ? int'(regWdata & 32'h309) : 0;
    mstat = (mstat & ~clr) | setb;
    if (regWrEn && regAddr == 8'h38) mcfg = regWdata & 32'h7FF;
    if (regWrEn && regAddr == 8'h50) mbc = regWdata & 32'h1FF;
    if (regWrEn && regAddr == 8'h3C) mbs = regWdata & 32'h3FF;
  endtask

  task automatic tick();
    bit expRx, expTx;
    #2;
    expRx = !xferWrite && mcnt != 0 && mq.size() != 16 && !(regWrEn && regAddr == 8'h40) && !(regWrEn && regAddr == 8'h50);
    expTx = xferWrite && mcnt != 0 && mtxLeft != 0 && !(regWrEn && regAddr == 8'h50);
    chk("R3 rxReady", 32'(cardRxReady), 32'(expRx));
    chk("R5 txValid", 32'(cardTxValid), 32'(expTx));
    if (expTx) chk("R5 txData", 32'(cardTxData), mtxWord & 32'hFF);
    if (regRdEn) chk(tagOf(regAddr), regRdata, expRead(regAddr));
    lastRxTake = cardRxValid && cardRxReady;
    if (cardTxValid && cardTxReady) gotTx.push_back(cardTxData);
    @(posedge clk);
    if (rstN) modelStep();
    @(negedge clk);
  endtask

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWdata = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic regRead(logic [7:0] a, output logic [31:0] v);
    regRdEn = 1; regAddr = a;
    #2 v = regRdata;
    tick();
    regRdEn = 0;
  endtask

  task automatic feedBytes(int n, logic [7:0] first, bit randomValid);
    int sent = 0;
    while (sent < n) begin
      cardRxValid = randomValid ? 1'($urandom % 2) : 1'b1;
      cardRxData = first + 8'(sent);
      tick();
      if (lastRxTake) sent++;
    end
    cardRxValid = 0;
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    regRead(8'h20, v); chk("R11 status", v, 32'h0);
    regRead(8'h34, v); chk("R11 debug", v, 32'h0);
    regRead(8'h38, v); chk("R11 config", v, 32'h0);
    regRead(8'h40, v); chk("R9 empty pop", v, 32'h0);
    regRead(8'h20, v); chk("R9 fifo error", v, 32'h8);
    regWrite(8'h20, 32'hFFFF);
    regRead(8'h20, v); chk("R10 clear", v, 32'h0);

    // R4 full words, little endian, with data and block flags
    regWrite(8'h38, 32'h110);
    regWrite(8'h3C, 4);
    regWrite(8'h50, 2);
    feedBytes(8, 8'h11, 0);
    tick();
    chk("R3 count exhausted", 32'(cardRxReady), 0);
    regRead(8'h34, v); chk("R1 R8 debug", v, 32'h21);
    regRead(8'h20, v); chk("R6 R7 status", v, 32'h301);
    regRead(8'h40, v); chk("R4 word0", v, 32'h14131211);
    regRead(8'h40, v); chk("R4 word1", v, 32'h18171615);
    regWrite(8'h20, 32'h309);
    regRead(8'h20, v); chk("R10 cleared", v, 32'h0);

    // R4 partial flush, R7 with odd block size
    regWrite(8'h3C, 3);
    regWrite(8'h50, 2);
    feedBytes(6, 8'hA1, 1);
    regRead(8'h20, v); chk("R7 block flag", v & 32'h200, 32'h200);
    regRead(8'h40, v); chk("R4 full", v, 32'hA4A3A2A1);
    regRead(8'h40, v); chk("R4 partial", v, 32'h0000A6A5);

    // R2 reload discards partial packing
    regWrite(8'h3C, 4);
    regWrite(8'h50, 1);
    feedBytes(2, 8'h31, 0);
    regWrite(8'h50, 1);
    feedBytes(4, 8'h55, 0);
    regRead(8'h34, v); chk("R2 fill", v >> 4, 32'h1);
    regRead(8'h40, v); chk("R2 word", v, 32'h58575655);

    // R3 full FIFO backpressure, R9 push when full
    regWrite(8'h38, 32'h0);
    regWrite(8'h3C, 64);
    regWrite(8'h50, 2);
    feedBytes(64, 8'h00, 0);
    cardRxValid = 1; tick(); cardRxValid = 0;
    chk("R3 full stalls", 32'(lastRxTake), 0);
    regRead(8'h34, v); chk("R1 full level", v >> 4, 32'd16);
    regWrite(8'h20, 32'h309);
    regWrite(8'h40, 32'hDEADBEEF);
    regRead(8'h20, v); chk("R9 push full", v, 32'h8);
    regRead(8'h40, v); chk("R1 order", v, 32'h03020100);
    for (int i = 0; i < 2000 && mcnt != 0; i++) begin
      cardRxValid = 1'($urandom % 2);
      cardRxData = 8'($urandom);
      if (i % 3 == 0) begin regRdEn = 1; regAddr = 8'h40; end
      tick();
      regRdEn = 0;
    end
    cardRxValid = 0;
    while (mq.size() != 0) regRead(8'h40, v);
    regRead(8'h34, v); chk("R1 drained", v >> 4, 32'h0);

    // R5 write direction, R8 state writable
    regWrite(8'h34, 32'h7);
    regRead(8'h34, v); chk("R8 writable", v, 32'h7);
    xferWrite = 1;
    regWrite(8'h20, 32'h309);
    regWrite(8'h38, 32'h110);
    regWrite(8'h40, 32'h04030201);
    regWrite(8'h40, 32'h08070605);
    regWrite(8'h40, 32'h0C0B0A09);
    regWrite(8'h3C, 6);
    gotTx.delete();
    regWrite(8'h50, 2);
    cardTxReady = 1;
    for (int i = 0; i < 40; i++) tick();
    chk("R5 byte count", gotTx.size(), 12);
    for (int i = 0; i < 12 && i < gotTx.size(); i++) chk("R5 lsb first", 32'(gotTx[i]), i + 1);
    regRead(8'h34, v); chk("R8 done", v, 32'h1);
    regRead(8'h20, v); chk("R6 R7 tx status", v, 32'h301);

    // R5 random backpressure with interleaved host pushes
    regWrite(8'h3C, 5);
    regWrite(8'h50, 3);
    gotTx.delete();
    for (int i = 0; i < 400; i++) begin
      cardTxReady = 1'($urandom % 2);
      if (i % 7 == 0 && i < 100) begin regWrEn = 1; regAddr = 8'h40; regWdata = $urandom; end
      tick();
      regWrEn = 0;
    end
    cardTxReady = 0;
    chk("R5 random tx count", gotTx.size(), 15);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule